// File: doc/BRIEF.md
# MDIO Management Master

This block is a bus-attached master for the two-wire PHY management link. It produces the management clock (MDC) from the system clock, serialises one management frame per command onto MDIO, and controls the MDIO output enable so that the pad is released while the PHY answers. Both the legacy framing and the extended framing for large PHY register spaces are supported. A global mode bit selects between them, and the meaning of the command opcode depends on that bit.

Software works through a bank of 64-bit registers. It first sets the divider, the mode and the preamble option, then turns the interface on. After that it loads outgoing data and writes a command word, and the command write launches the frame. Software then polls a busy bit held inside the write-data or read-data register. A read in extended mode issues two frames, an address frame followed by a read frame, under a single busy indication. When a read completes, a valid bit reports whether the PHY answered.

Top module: `mdio_master`

## Requirements
- R1: After reset, MDC is low, MDIO is released (output enable 0), and the command, write-data, read-data, clock/mode and enable registers all read as zero.
- R2: Bit 0 of the enable register (offset 0x20) turns the interface on. While it is 0, a command write launches nothing and MDC stays low. Writing it to 0 during a frame stops that frame at the next clock edge, releases MDIO and clears both busy bits.
- R3: The command register (offset 0x00) holds the register/device number in [4:0], the PHY address in [12:8] and the opcode in [17:16], and reads back the last command accepted. In legacy mode (offset 0x18 bit 24 = 0), opcode 0 sends a write frame, MSB first. Its bits are start 01, wire opcode 01, PHY address, register number, turnaround 10, then write-data bits [15:0] (write-data register at offset 0x08).
- R4: In legacy mode, opcode 1 sends a read frame with start 01 and wire opcode 10. The block releases MDIO from the first turnaround bit until the end of the frame.
- R5: When a read finishes, read-data bit 16 (valid) is 1 and bits [15:0] hold the 16 bits sampled after the turnaround, MSB first, if the PHY held MDIO low during the second turnaround bit. Otherwise both valid and the data read as 0. Valid and data are cleared when a read is launched.
- R6: In extended mode (offset 0x18 bit 24 = 1) the start code is 00. Opcode 0 sends an address frame (wire opcode 00) and opcode 1 sends a write frame (wire opcode 01). Both carry write-data bits [15:0] after turnaround 10.
- R7: In extended mode, opcode 3 sends an address frame carrying write-data [15:0], then, with no gap, a read frame (wire opcode 11) to the same PHY and device number.
- R8: When bit 12 of offset 0x18 is 1, 32 one bits are driven on MDIO before every frame, including each frame of an extended read.
- R9: Each bit lasts one MDC period of 2*(D+1) system clocks, where D is bits [7:0] of offset 0x18. MDC is low for the first D+1 clocks of each bit and high for the rest. MDIO changes only at bit boundaries and is sampled at the rising MDC edge.
- R10: Write-data bit 17 is busy during write and address frames, and read-data bit 17 is busy during read sequences, including both frames of an extended read. Busy clears exactly one MDC period after the end of the last data bit, and during that period MDC stays low and MDIO is released.
- R11: A command written while either busy bit is set is ignored and does not change the command readback. Unassigned opcodes (2 and 3 in legacy mode, 2 in extended mode) launch nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte offset of the register (64-bit aligned) |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = drive) |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
Legacy write and read frames are run with the preamble off and on and with three divider settings. Comparing the line state on every clock separates framing errors (start code, opcode, turnaround) from bit-period and sampling-point errors. Reads are run against both an answering PHY and a silent one, which separates valid set from valid cleared and checks that data is forced to zero. Extended-mode address, write and two-frame read sequences check that the opcode is remapped and that busy is held across the chained frames. Commands issued while busy, while disabled or with unassigned opcodes, and a mid-frame disable, show that nothing extra reaches the line.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = 32;
  localparam int TA_SLOT    = 14;  // first turnaround bit inside the frame

  localparam logic [5:0] OFF_CMD  = 6'h00;
  localparam logic [5:0] OFF_WDAT = 6'h08;
  localparam logic [5:0] OFF_RDAT = 6'h10;
  localparam logic [5:0] OFF_CLK  = 6'h18;
  localparam logic [5:0] OFF_EN   = 6'h20;

  localparam int BIT_BUSY  = 17;
  localparam int BIT_VALID = 16;
  localparam int BIT_PRE   = 12;
  localparam int BIT_EXT   = 24;
  localparam int OP_LSB    = 16;
  localparam int PHY_LSB   = 8;

  typedef enum logic [2:0] {
    K_NONE, K_WR22, K_RD22, K_ADDR45, K_WR45, K_RD45
  } cmd_kind_e;

  function automatic cmd_kind_e decode_op(input logic ext, input logic [1:0] op);
    cmd_kind_e k;
    k = K_NONE;
    if (!ext) begin
      if (op == 2'd0) k = K_WR22;
      else if (op == 2'd1) k = K_RD22;
    end else begin
      if (op == 2'd0) k = K_ADDR45;
      else if (op == 2'd1) k = K_WR45;
      else if (op == 2'd3) k = K_RD45;
    end
    return k;
  endfunction

  // opcode placed on the wire by the first frame of a command
  function automatic logic [1:0] first_wire_op(input cmd_kind_e k);
    logic [1:0] w;
    case (k)
      K_WR22, K_WR45: w = 2'b01;
      K_RD22:         w = 2'b10;
      default:        w = 2'b00;  // address frame, also opens an extended read
    endcase
    return w;
  endfunction

  function automatic logic kind_is_read(input cmd_kind_e k);
    return (k == K_RD22) || (k == K_RD45);
  endfunction

  function automatic logic [FRAME_BITS-1:0] build_frame(
      input logic ext, input logic [1:0] wop, input logic [4:0] phy,
      input logic [4:0] regn, input logic [15:0] data);
    return {1'b0, ~ext, wop, phy, regn, 2'b10, data};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             slot_end,
  output logic             sample,
  output logic             mdc_hi
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_ext;
  logic [CNT_W-1:0] last_cnt;

  assign half_ext = {1'b0, half};
  assign last_cnt = {half, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (!run || slot_end) cnt <= '0;
    else                       cnt <= cnt + CNT_W'(1);
  end

  assign slot_end = run && (cnt >= last_cnt);
  assign sample   = run && (cnt == half_ext + CNT_W'(1));
  assign mdc_hi   = run && (cnt > half_ext);
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  abort,
  input  logic                  load,
  input  logic                  load_read,
  input  logic                  load_pre,
  input  logic [FRAME_BITS-1:0] load_bits,
  input  logic                  slot_end,
  input  logic                  sample,
  input  logic                  mdio_i,
  output logic                  active,
  output logic                  clk_gate,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic                  done,
  output logic                  ta_ok,
  output logic [15:0]           cap
);
  localparam int IDX_W = 7;
  localparam logic [IDX_W-1:0] IDX_PRE  = IDX_W'(PRE_BITS);
  localparam logic [IDX_W-1:0] IDX_TAIL = IDX_W'(PRE_BITS + FRAME_BITS);
  localparam logic [IDX_W-1:0] FB_TA1   = IDX_W'(TA_SLOT);
  localparam logic [IDX_W-1:0] FB_TA2   = IDX_W'(TA_SLOT + 1);
  localparam logic [IDX_W-1:0] FB_DATA  = IDX_W'(TA_SLOT + 2);

  logic [IDX_W-1:0]      idx;
  logic [FRAME_BITS-1:0] sreg;
  logic                  rd_q;
  logic [IDX_W-1:0]      fb;
  logic                  in_pre, in_frm, in_tail;

  assign fb      = idx - IDX_PRE;
  assign in_pre  = idx < IDX_PRE;
  assign in_tail = idx == IDX_TAIL;
  assign in_frm  = !in_pre && !in_tail;

  assign mdio_oe  = active && (in_pre || (in_frm && !(rd_q && fb >= FB_TA1)));
  assign mdio_o   = mdio_oe && (in_pre || sreg[FRAME_BITS-1]);
  assign done     = active && slot_end && in_tail;
  assign clk_gate = active && !in_tail;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      sreg   <= '0;
      rd_q   <= 1'b0;
      ta_ok  <= 1'b0;
      cap    <= '0;
    end else if (abort) begin
      active <= 1'b0;
    end else if (load) begin
      active <= 1'b1;
      idx    <= load_pre ? '0 : IDX_PRE;
      sreg   <= load_bits;
      rd_q   <= load_read;
      ta_ok  <= 1'b0;
      cap    <= '0;
    end else if (active) begin
      if (sample && in_frm && rd_q) begin
        if (fb == FB_TA2) ta_ok <= !mdio_i;
        if (fb >= FB_DATA) cap <= {cap[14:0], mdio_i};
      end
      if (slot_end) begin
        if (in_tail) active <= 1'b0;
        else begin
          idx <= idx + IDX_W'(1);
          if (in_frm) sreg <= {sreg[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enabled,
  input  logic                  abort,
  input  logic                  cmd_go,
  input  logic [1:0]            cmd_op,
  input  logic [4:0]            cmd_phy,
  input  logic [4:0]            cmd_reg,
  input  logic                  ext_mode,
  input  logic [15:0]           wdat,
  input  logic                  frame_done,
  input  logic                  ta_ok,
  input  logic [15:0]           cap,
  output logic                  accept,
  output logic                  load,
  output logic                  load_read,
  output logic [FRAME_BITS-1:0] load_bits,
  output logic                  wr_pend,
  output logic                  rd_pend,
  output logic                  rd_valid,
  output logic [15:0]           rd_data
);
  cmd_kind_e  kind;
  logic       busy;
  logic       follow;
  logic       second;
  logic [4:0] sv_phy, sv_reg;

  assign kind   = decode_op(ext_mode, cmd_op);
  assign busy   = wr_pend || rd_pend;
  assign accept = cmd_go && enabled && !busy && (kind != K_NONE);
  assign second = frame_done && follow;
  assign load   = accept || second;

  assign load_read = accept ? (kind == K_RD22) : 1'b1;
  assign load_bits = accept
    ? build_frame(ext_mode, first_wire_op(kind), cmd_phy, cmd_reg, wdat)
    : build_frame(1'b1, 2'b11, sv_phy, sv_reg, 16'hFFFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_pend  <= 1'b0;
      rd_pend  <= 1'b0;
      follow   <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      sv_phy   <= '0;
      sv_reg   <= '0;
    end else if (abort) begin
      wr_pend <= 1'b0;
      rd_pend <= 1'b0;
      follow  <= 1'b0;
    end else if (accept) begin
      if (kind_is_read(kind)) begin
        rd_pend  <= 1'b1;
        rd_valid <= 1'b0;
        rd_data  <= '0;
      end else begin
        wr_pend <= 1'b1;
      end
      follow <= (kind == K_RD45);
      sv_phy <= cmd_phy;
      sv_reg <= cmd_reg;
    end else if (second) begin
      follow <= 1'b0;
    end else if (frame_done) begin
      wr_pend <= 1'b0;
      if (rd_pend) begin
        rd_pend  <= 1'b0;
        rd_valid <= ta_ok;
        rd_data  <= ta_ok ? cap : 16'h0000;
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int AW    = 6,
  parameter int DW    = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          mdc,
  output logic          mdio_o,
  output logic          mdio_oe,
  input  logic          mdio_i
);
  localparam int CMD_W = 2 + 5 + 5;

  logic [1:0]       cmd_op_q;
  logic [4:0]       cmd_phy_q, cmd_reg_q;
  logic [15:0]      wdat_q;
  logic             ext_q, pre_q, en_q;
  logic [DIV_W-1:0] div_q;

  logic             sel_cmd, sel_wdat, sel_rdat, sel_clk, sel_en;
  logic             wr_en_reg, en_next, abort;
  logic [CMD_W-1:0] cmd_word;

  logic             accept, load, load_read;
  logic [FRAME_BITS-1:0] load_bits;
  logic             wr_pend, rd_pend, rd_valid;
  logic [15:0]      rd_data;
  logic             slot_end, sample, mdc_hi;
  logic             active, clk_gate, frame_done, ta_ok;
  logic [15:0]      cap;
  logic             unused_bits;

  assign sel_cmd  = reg_addr == AW'(OFF_CMD);
  assign sel_wdat = reg_addr == AW'(OFF_WDAT);
  assign sel_rdat = reg_addr == AW'(OFF_RDAT);
  assign sel_clk  = reg_addr == AW'(OFF_CLK);
  assign sel_en   = reg_addr == AW'(OFF_EN);

  assign wr_en_reg = reg_we && sel_en;
  assign en_next   = wr_en_reg ? reg_wdata[0] : en_q;
  assign abort     = !en_next;
  assign cmd_word  = {cmd_op_q, cmd_phy_q, cmd_reg_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_op_q  <= '0;
      cmd_phy_q <= '0;
      cmd_reg_q <= '0;
      wdat_q    <= '0;
      ext_q     <= 1'b0;
      pre_q     <= 1'b0;
      div_q     <= '0;
      en_q      <= 1'b0;
    end else begin
      en_q <= en_next;
      if (accept) begin
        cmd_op_q  <= reg_wdata[OP_LSB+1:OP_LSB];
        cmd_phy_q <= reg_wdata[PHY_LSB+4:PHY_LSB];
        cmd_reg_q <= reg_wdata[4:0];
      end
      if (reg_we && sel_wdat) wdat_q <= reg_wdata[15:0];
      if (reg_we && sel_clk) begin
        ext_q <= reg_wdata[BIT_EXT];
        pre_q <= reg_wdata[BIT_PRE];
        div_q <= reg_wdata[DIV_W-1:0];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (sel_cmd) begin
      reg_rdata[OP_LSB+1:OP_LSB]   = cmd_op_q;
      reg_rdata[PHY_LSB+4:PHY_LSB] = cmd_phy_q;
      reg_rdata[4:0]               = cmd_reg_q;
    end else if (sel_wdat) begin
      reg_rdata[BIT_BUSY] = wr_pend;
      reg_rdata[15:0]     = wdat_q;
    end else if (sel_rdat) begin
      reg_rdata[BIT_BUSY]  = rd_pend;
      reg_rdata[BIT_VALID] = rd_valid;
      reg_rdata[15:0]      = rd_data;
    end else if (sel_clk) begin
      reg_rdata[BIT_EXT]     = ext_q;
      reg_rdata[BIT_PRE]     = pre_q;
      reg_rdata[DIV_W-1:0]   = div_q;
    end else if (sel_en) begin
      reg_rdata[0] = en_q;
    end
  end

  mdio_seq u_seq (
    .clk(clk), .rst_n(rst_n), .enabled(en_q), .abort(abort),
    .cmd_go(reg_we && sel_cmd),
    .cmd_op(reg_wdata[OP_LSB+1:OP_LSB]),
    .cmd_phy(reg_wdata[PHY_LSB+4:PHY_LSB]),
    .cmd_reg(reg_wdata[4:0]),
    .ext_mode(ext_q), .wdat(wdat_q),
    .frame_done(frame_done), .ta_ok(ta_ok), .cap(cap),
    .accept(accept), .load(load), .load_read(load_read), .load_bits(load_bits),
    .wr_pend(wr_pend), .rd_pend(rd_pend), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(active), .half(div_q),
    .slot_end(slot_end), .sample(sample), .mdc_hi(mdc_hi)
  );

  mdio_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .abort(abort), .load(load),
    .load_read(load_read), .load_pre(pre_q), .load_bits(load_bits),
    .slot_end(slot_end), .sample(sample), .mdio_i(mdio_i),
    .active(active), .clk_gate(clk_gate), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done(frame_done), .ta_ok(ta_ok), .cap(cap)
  );

  assign mdc = mdc_hi && clk_gate;

  assign unused_bits = ^{reg_wdata[DW-1:BIT_EXT+1], reg_wdata[BIT_EXT-1:OP_LSB+2],
                         reg_wdata[15:BIT_PRE+1], reg_wdata[BIT_PRE-1:PHY_LSB+5],
                         reg_wdata[PHY_LSB-1:5]};
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mdc,
  input logic        mdio_oe,
  input logic        en_q,
  input logic        wr_pend,
  input logic        rd_pend,
  input logic        rd_valid,
  input logic [15:0] rd_data,
  input logic [11:0] cmd_word
);
  logic busy;
  assign busy = wr_pend || rd_pend;

  // R2: a disabled interface keeps the line quiet
  p_idle_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (!mdc && !mdio_oe));

  // R9: MDC toggles only inside a busy sequence
  p_mdc_needs_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> busy);

  // R10: MDIO is driven only while a sequence is busy
  p_oe_needs_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy);

  // R10: a sequence is either a write kind or a read kind, never both
  p_one_busy_kind_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_pend && rd_pend));

  // R10: busy ends after a quiet period with MDC low
  p_quiet_tail_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && en_q) |-> !$past(mdc));

  // R11: command readback frozen while busy
  p_cmd_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cmd_word));

  // R5: no valid flag means zero data
  p_invalid_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == 16'h0000));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_oe(mdio_oe), .en_q(en_q),
  .wr_pend(wr_pend), .rd_pend(rd_pend), .rd_valid(rd_valid),
  .rd_data(rd_data), .cmd_word(cmd_word)
);

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  always #2 clk = ~clk;  // 250 MHz

  mdio_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  typedef struct packed { logic mdc; logic oe; logic o; logic din; } exp_t;
  exp_t q[$];

  int tests = 0, fails = 0, mism = 0, pmism = 0;
  bit watch = 0;

  // per-clock comparison against the behavioural line model
  always @(negedge clk) begin
    exp_t e;
    bit busy_exp;
    if (rst_n) begin
      busy_exp = (q.size() > 0);
      if (busy_exp) e = q.pop_front();
      else e = '{mdc: 1'b0, oe: 1'b0, o: 1'b0, din: 1'b1};
      if (mdc !== e.mdc || mdio_oe !== e.oe || (e.oe && mdio_o !== e.o)) mism++;
      if (watch && reg_rdata[17] !== busy_exp) pmism++;
      mdio_i = e.din;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [63:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [63:0] d);
    @(posedge clk); #1;
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [63:0] mk_cmd(input int op, input int phy, input int rg);
    return 64'((op << 16) | (phy << 8) | rg);
  endfunction

  function automatic logic [31:0] line_bits(input bit ext, input bit [1:0] wop,
      input bit [4:0] phy, input bit [4:0] rg, input bit [15:0] d);
    return {1'b0, ~ext, wop, phy, rg, 2'b10, d};
  endfunction

  // pushes the expected line state, one entry per system clock
  task automatic push_frame(input bit pre, input int h, input logic [31:0] bits,
      input bit is_rd, input bit respond, input logic [15:0] val);
    int nslots;
    nslots = (pre ? 32 : 0) + 33;
    for (int s = 0; s < nslots; s++) begin
      int fb;
      bit oe, o, din;
      fb = pre ? s - 32 : s;
      if (fb < 0) begin oe = 1; o = 1; end
      else if (fb == 32) begin oe = 0; o = 0; end
      else if (is_rd && fb >= 14) begin oe = 0; o = 0; end
      else begin oe = 1; o = bits[31-fb]; end
      din = 1;
      if (is_rd && fb == 15) din = !respond;
      if (is_rd && respond && fb >= 16 && fb < 32) din = val[31-fb];
      for (int c = 0; c < 2*h; c++)
        q.push_back('{mdc: (fb != 32 && c >= h), oe: oe, o: o, din: din});
    end
  endtask

  task automatic settle(input string tag);
    while (q.size() > 0) @(posedge clk);
    repeat (3) @(posedge clk);
    watch = 0;
    check({tag, " line"}, 64'(mism), 64'd0);
    check("R10 busy timing", 64'(pmism), 64'd0);
    mism = 0; pmism = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [63:0] v;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    #1;
    check("R1 mdc", 64'(mdc), 64'd0);
    check("R1 oe", 64'(mdio_oe), 64'd0);
    rd(6'h00, v); check("R1 cmd", v, 64'd0);
    rd(6'h08, v); check("R1 wdat", v, 64'd0);
    rd(6'h10, v); check("R1 rdat", v, 64'd0);
    rd(6'h18, v); check("R1 clk", v, 64'd0);
    rd(6'h20, v); check("R1 en", v, 64'd0);

    // R2 disabled: command ignored
    wr(6'h00, mk_cmd(0, 5, 3));
    repeat (20) @(posedge clk);
    check("R2 no frame when off", 64'(mism), 64'd0);
    rd(6'h08, v); check("R2 no busy when off", 64'(v[17]), 64'd0);
    rd(6'h00, v); check("R2 cmd not taken", v, 64'd0);

    // R3 legacy write, D=1
    wr(6'h20, 64'd1);
    wr(6'h18, 64'd1);
    wr(6'h08, 64'h1234);
    wr(6'h00, mk_cmd(0, 5, 5'h1A));
    push_frame(0, 2, line_bits(0, 2'b01, 5, 5'h1A, 16'h1234), 0, 0, 0);
    reg_addr = 6'h08; watch = 1;
    settle("R3 legacy write");
    rd(6'h00, v); check("R3 cmd readback", v, mk_cmd(0, 5, 5'h1A));

    // R8 R9 preamble with D=0
    wr(6'h18, 64'h1000);
    wr(6'h08, 64'h8001);
    wr(6'h00, mk_cmd(0, 31, 0));
    push_frame(1, 1, line_bits(0, 2'b01, 31, 0, 16'h8001), 0, 0, 0);
    reg_addr = 6'h08; watch = 1;
    settle("R8 R9 preamble D=0");

    // R4 R5 R9 legacy read, D=3, PHY answers
    wr(6'h18, 64'd3);
    wr(6'h00, mk_cmd(1, 2, 1));
    push_frame(0, 4, line_bits(0, 2'b10, 2, 1, 16'hFFFF), 1, 1, 16'hA5C3);
    reg_addr = 6'h10; watch = 1;
    settle("R4 R9 legacy read D=3");
    rd(6'h10, v); check("R5 valid data", v, 64'h1A5C3);

    // R5 silent PHY
    wr(6'h00, mk_cmd(1, 4, 9));
    push_frame(0, 4, line_bits(0, 2'b10, 4, 9, 16'hFFFF), 1, 0, 0);
    reg_addr = 6'h10; watch = 1;
    settle("R4 silent read");
    rd(6'h10, v); check("R5 no answer", v, 64'd0);

    // R6 extended address and write frames
    wr(6'h18, 64'h100_0001);
    wr(6'h08, 64'h0ABC);
    wr(6'h00, mk_cmd(0, 3, 7));
    push_frame(0, 2, line_bits(1, 2'b00, 3, 7, 16'h0ABC), 0, 0, 0);
    reg_addr = 6'h08; watch = 1;
    settle("R6 ext address");
    wr(6'h08, 64'h5555);
    wr(6'h00, mk_cmd(1, 3, 7));
    push_frame(0, 2, line_bits(1, 2'b01, 3, 7, 16'h5555), 0, 0, 0);
    reg_addr = 6'h08; watch = 1;
    settle("R6 ext write");

    // R7 R8 extended read with preamble: two chained frames
    wr(6'h18, 64'h100_1001);
    wr(6'h08, 64'h0020);
    wr(6'h00, mk_cmd(3, 9, 1));
    push_frame(1, 2, line_bits(1, 2'b00, 9, 1, 16'h0020), 0, 0, 0);
    push_frame(1, 2, line_bits(1, 2'b11, 9, 1, 16'hFFFF), 1, 1, 16'h1357);
    reg_addr = 6'h10; watch = 1;
    settle("R7 R8 ext read");
    rd(6'h10, v); check("R7 ext read data", v, 64'h11357);

    // R11 command while busy is ignored
    wr(6'h18, 64'h100_0001);
    wr(6'h00, mk_cmd(1, 6, 2));
    push_frame(0, 2, line_bits(1, 2'b01, 6, 2, 16'h0020), 0, 0, 0);
    repeat (20) @(posedge clk);
    wr(6'h00, mk_cmd(0, 12, 12));
    settle("R11 busy ignore");
    rd(6'h00, v); check("R11 cmd readback kept", v, mk_cmd(1, 6, 2));

    // R11 unassigned opcodes
    wr(6'h00, mk_cmd(2, 1, 1));
    repeat (20) @(posedge clk);
    check("R11 ext op2 no frame", 64'(mism), 64'd0);
    rd(6'h08, v); check("R11 ext op2 no busy", 64'(v[17]), 64'd0);
    wr(6'h18, 64'd1);
    wr(6'h00, mk_cmd(3, 1, 1));
    repeat (20) @(posedge clk);
    check("R11 legacy op3 no frame", 64'(mism), 64'd0);
    rd(6'h10, v); check("R11 legacy op3 no busy", 64'(v[17]), 64'd0);
    mism = 0;

    // R2 abort by disable mid-frame
    wr(6'h18, 64'h1001);
    wr(6'h00, mk_cmd(0, 8, 8));
    push_frame(1, 2, line_bits(0, 2'b01, 8, 8, 16'h0020), 0, 0, 0);
    repeat (30) @(posedge clk);
    wr(6'h20, 64'd0);
    q.delete();
    repeat (10) @(posedge clk);
    check("R2 abort quiet", 64'(mism), 64'd0);
    rd(6'h08, v); check("R2 abort clears busy", 64'(v[17]), 64'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule